// File: doc/BRIEF.md
# Free-Running Pin Sampler with Word Interrupt

The block watches one asynchronous input, such as the output of an infrared receiver. It takes a sample at a programmable rate and packs the samples into a 32-bit shift register. Samples run continuously with no framing, so a word boundary has no fixed link to any edge or feature of the input. Software must decode the input's bit-level structure from the raw sample stream.

Each new sample enters at the most significant end, and the older samples move one place toward bit 0. Every 32nd sample completes a word. The completed word is copied into a holding register, so software can read it while the next word fills. A completed word also sets a sticky status flag at bit 18. An interrupt line follows that flag when the matching mask bit is set. A second flag records an overrun: a word that completed while the previous completion was still unacknowledged. A small register port gives access to the enable, the rate divider, the held word, the status and the mask.

Top module: `pin_sampler`

## Requirements
- R1: After reset, every register reads as zero, the rate divider reads as its reset parameter (default 0), and `irq_o` is low.
- R2: The pin passes through a two-stage synchronizer. The value sampled at a sampling edge is the pin level from two clocks before that edge.
- R3: While enabled, a sample is taken each time the prescaler count is at or above the programmed divider value D, and the count then restarts. The result is one sample every D+1 clocks.
- R4: On each sample, the sample enters bit 31 and the previous contents shift right by one place. In a completed word, bit 0 holds the oldest of the 32 samples and bit 31 the newest.
- R5: The 32nd sample of a word copies the full word to the word register (address 2) in the same clock and sets status bit 18. The word register keeps its value between completions.
- R6: `irq_o` is high exactly one clock after status bit 18 and mask bit 18 (address 4) are both set, and is low otherwise.
- R7: Writing to the status register (address 3) clears bit 18 and bit 19 where the written data has a 1. Bits written as 0 are unaffected. A word completing in the same clock as the clear leaves bit 18 set.
- R8: Status bit 19 (overrun) is set when a word completes while bit 18 is set and is not being cleared in that same clock.
- R9: Control bit 0 (address 0) enables sampling. While it is 0, no samples are taken and both the prescaler and the sample count are held at zero. Re-enabling therefore starts a fresh 32-sample word.
- R10: A read with `rd_en_i` high returns data on `rdata_o` on the following clock, from these addresses: 0 control, 1 rate divider, 2 word, 3 status, 4 mask. Any other address reads as zero. `rdata_o` holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous pin to sample |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one clock after the read strobe |
| irq_o | output | 1 | Word-complete interrupt, masked |

## Verification
The pin is driven with four patterns: held high, held low, a slow square wave and a pseudo-random sequence. A held-high pin gives an all-ones word. This checks the completion count and the word copy without any dependence on alignment. The square wave and the pseudo-random sequence make every bit position distinct, so they expose a reversed shift direction, a wrong synchronizer depth or an off-by-one in the divider. Further sequences cover overrun from two unacknowledged words, disabling sampling mid-word, clears that write zero, and a held interrupt mask. Each of these is checked against a per-clock behavioural model.

// File: rtl/pin_sampler_pkg.sv
package pin_sampler_pkg;
  localparam int REG_ADDR_W = 3;
  localparam logic [REG_ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADR_RATE = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADR_WORD = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADR_STAT = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADR_MASK = 3'd4;
  localparam int DONE_BIT = 18;
  localparam int OVR_BIT  = 19;
endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ps_prescaler.sv
module ps_prescaler #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = enable_i && (cnt_q >= period_i);

  always_ff @(posedge clk) begin
    if (rst || !enable_i) cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/ps_capture.sv
module ps_capture #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic              tick_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  logic [WORD_W-1:0] shift_q, shift_nx, hold_q;
  logic [IDX_W-1:0]  idx_q;

  assign shift_nx = {bit_i, shift_q[WORD_W-1:1]};
  assign done_o   = tick_i && (idx_q == LAST);
  assign word_o   = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      hold_q  <= '0;
      idx_q   <= '0;
    end else begin
      if (!enable_i) idx_q <= '0;
      else if (tick_i) begin
        shift_q <= shift_nx;
        if (idx_q == LAST) begin
          hold_q <= shift_nx;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> $stable(hold_q)); // R5
  AST_IDX_CLEARED_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (idx_q == '0)); // R9
endmodule

// File: rtl/ps_regs.sv
module ps_regs
  import pin_sampler_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int PER_W        = 16,
  parameter int RESET_PERIOD = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  word_done_i,
  input  logic [DATA_W-1:0]     word_i,
  output logic                  enable_o,
  output logic [PER_W-1:0]      period_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  irq_o
);
  logic              en_q, done_q, ovr_q, irq_q;
  logic [PER_W-1:0]  per_q;
  logic [DATA_W-1:0] mask_q, rdata_q, stat_w, rd_mux;
  logic              wr_stat, clr_done, clr_ovr;

  assign wr_stat  = wr_en_i && (addr_i == ADR_STAT);
  assign clr_done = wr_stat && wdata_i[DONE_BIT];
  assign clr_ovr  = wr_stat && wdata_i[OVR_BIT];

  always_comb begin
    stat_w           = '0;
    stat_w[DONE_BIT] = done_q;
    stat_w[OVR_BIT]  = ovr_q;
    case (addr_i)
      ADR_CTRL: rd_mux = {{(DATA_W-1){1'b0}}, en_q};
      ADR_RATE: rd_mux = {{(DATA_W-PER_W){1'b0}}, per_q};
      ADR_WORD: rd_mux = word_i;
      ADR_STAT: rd_mux = stat_w;
      ADR_MASK: rd_mux = mask_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      per_q   <= PER_W'(RESET_PERIOD);
      mask_q  <= '0;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_en_i && addr_i == ADR_CTRL) en_q   <= wdata_i[0];
      if (wr_en_i && addr_i == ADR_RATE) per_q  <= wdata_i[PER_W-1:0];
      if (wr_en_i && addr_i == ADR_MASK) mask_q <= wdata_i;
      if (word_done_i)   done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
      if (word_done_i && done_q && !clr_done) ovr_q <= 1'b1;
      else if (clr_ovr)                       ovr_q <= 1'b0;
      irq_q <= done_q && mask_q[DONE_BIT];
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign enable_o = en_q;
  assign period_o = per_q;
  assign rdata_o  = rdata_q;
  assign irq_o    = irq_q;

  AST_DONE_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
    word_done_i |=> done_q); // R5
  AST_OVR_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $past(done_q)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(mask_q[DONE_BIT])); // R6
endmodule

// File: rtl/pin_sampler.sv
module pin_sampler
  import pin_sampler_pkg::*;
#(
  parameter int WORD_W       = 32,
  parameter int PER_W        = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int RESET_PERIOD = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pin_i,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0]     wdata_i,
  output logic [WORD_W-1:0]     rdata_o,
  output logic                  irq_o
);
  logic              pin_sync, tick, enable, word_done;
  logic [PER_W-1:0]  period;
  logic [WORD_W-1:0] word;

  ps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_sync));

  ps_prescaler #(.CNT_W(PER_W)) u_presc (
    .clk(clk), .rst(rst), .enable_i(enable), .period_i(period), .tick_o(tick));

  ps_capture #(.WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst(rst), .enable_i(enable), .tick_i(tick), .bit_i(pin_sync),
    .done_o(word_done), .word_o(word));

  ps_regs #(.DATA_W(WORD_W), .PER_W(PER_W), .RESET_PERIOD(RESET_PERIOD)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .word_done_i(word_done), .word_i(word),
    .enable_o(enable), .period_o(period), .rdata_o(rdata_o), .irq_o(irq_o));
endmodule

// File: tb/test_pin_sampler.sv
module test_pin_sampler;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic irq_o;

  int checks = 0, failures = 0, cyc = 0;
  int mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int phase_cnt = 0;

  always #2.5 clk = ~clk;

  pin_sampler i_pin_sampler (
    .clk(clk), .rst(rst), .pin_i(pin), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .irq_o(irq_o));

  // pin stimulus: 0 low, 1 high, 2 square wave period 10, 3 pseudo-random
  always @(negedge clk) begin
    phase_cnt <= phase_cnt + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      0: pin <= 1'b0;
      1: pin <= 1'b1;
      2: pin <= ((phase_cnt / 5) % 2) == 1;
      default: pin <= lfsr[0];
    endcase
  end

  // behavioural reference model
  logic m_s1, m_s2, m_en, m_done, m_ovr, m_irq;
  int m_cnt, m_nsamp, m_per;
  logic [31:0] m_sh, m_hold, m_mask, m_rdata;

  function automatic logic [31:0] model_read(input logic [2:0] a);
    logic [31:0] v;
    v = 32'h0;
    case (a)
      3'd0: v = {31'h0, m_en};
      3'd1: v = m_per;
      3'd2: v = m_hold;
      3'd3: begin v[18] = m_done; v[19] = m_ovr; end
      3'd4: v = m_mask;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    logic smp, ev, clr18, clr19, n_done, n_ovr;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_en = 0; m_done = 0; m_ovr = 0; m_irq = 0;
      m_cnt = 0; m_nsamp = 0; m_per = 0;
      m_sh = 0; m_hold = 0; m_mask = 0; m_rdata = 0;
    end else begin
      if (rd_en) m_rdata = model_read(addr);
      smp = m_en && (m_cnt >= m_per);
      ev = 0;
      if (smp) begin
        m_sh = (m_sh >> 1) | (32'(m_s2) << 31);
        if (m_nsamp == 31) begin m_hold = m_sh; m_nsamp = 0; ev = 1; end
        else m_nsamp = m_nsamp + 1;
      end
      if (!m_en) begin m_cnt = 0; m_nsamp = 0; end
      else if (smp) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      clr18 = wr_en && addr == 3'd3 && wdata[18];
      clr19 = wr_en && addr == 3'd3 && wdata[19];
      n_done = ev ? 1'b1 : (m_done && !clr18);
      n_ovr  = (ev && m_done && !clr18) ? 1'b1 : (m_ovr && !clr19);
      m_irq = m_done && m_mask[18];
      m_done = n_done; m_ovr = n_ovr;
      m_s2 = m_s1; m_s1 = pin;
      if (wr_en && addr == 3'd0) m_en = wdata[0];
      if (wr_en && addr == 3'd1) m_per = int'(wdata[15:0]);
      if (wr_en && addr == 3'd4) m_mask = wdata;
    end
  end

  // per-clock comparison of the outputs
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (irq_o !== m_irq) begin
        failures++;
        $display("FAIL R6 (timing R3, R2) cycle %0d irq_o=%0b expected %0b", cyc, irq_o, m_irq);
      end
      checks++;
      if (rdata_o !== m_rdata) begin
        failures++;
        $display("FAIL R10 cycle %0d rdata_o=%h expected %h", cyc, rdata_o, m_rdata);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    v = rdata_o;
    checks++;
    if (v !== m_rdata) begin
      failures++;
      $display("FAIL %s read addr %0d actual=%h expected=%h", tag, a, v, m_rdata);
    end
  endtask

  task automatic expect_eq(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_irq(input int limit);
    for (int i = 0; i < limit && !irq_o; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    mode = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset values, R10: unmapped address reads zero
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), "R1", v);
      expect_eq(v, 32'h0, "R1 reset value");
    end
    rd(3'd6, "R10", v);
    expect_eq(v, 32'h0, "R10 unmapped address");
    expect_eq({31'h0, irq_o}, 32'h0, "R1 irq after reset");

    // R3/R5: divider 0, pin held high, word of all ones
    wr(3'd1, 32'h0);
    wr(3'd4, 32'h1 << 18);
    wr(3'd0, 32'h1);
    wait_irq(200);
    expect_eq({31'h0, irq_o}, 32'h1, "R6 irq after word");
    rd(3'd2, "R5", v);
    expect_eq(v, 32'hFFFF_FFFF, "R5 all-ones word");

    // R7: write zero leaves flags, write one clears
    wr(3'd0, 32'h0);
    rd(3'd3, "R7", v);
    wr(3'd3, 32'h0);
    rd(3'd3, "R7", v);
    expect_eq(v & (32'h1 << 18), 32'h1 << 18, "R7 zero write keeps bit 18");
    wr(3'd3, 32'h000C_0000);
    rd(3'd3, "R7", v);
    expect_eq(v, 32'h0, "R7 clear");

    // R8/R4: divider 3, pseudo-random pin, two unacknowledged words
    mode = 3;
    wr(3'd1, 32'd3);
    rd(3'd1, "R10", v);
    expect_eq(v, 32'd3, "R3 divider readback");
    wr(3'd0, 32'h1);
    repeat (300) @(negedge clk);
    rd(3'd3, "R8", v);
    expect_eq(v, 32'h000C_0000, "R8 overrun with done");
    rd(3'd2, "R4", v);

    // R9: disable mid-word, nothing completes
    wr(3'd3, 32'h000C_0000);
    repeat (60) @(negedge clk);
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h000C_0000);
    repeat (400) @(negedge clk);
    rd(3'd3, "R9", v);
    expect_eq(v, 32'h0, "R9 no completion while disabled");
    wr(3'd0, 32'h1);
    repeat (140) @(negedge clk);
    rd(3'd3, "R9", v);
    rd(3'd2, "R9", v);

    // R6: mask off, flag set, irq stays low
    wr(3'd4, 32'h0);
    wr(3'd3, 32'h000C_0000);
    repeat (200) @(negedge clk);
    rd(3'd3, "R6", v);
    expect_eq(v & (32'h1 << 18), 32'h1 << 18, "R6 flag set with mask off");
    expect_eq({31'h0, irq_o}, 32'h0, "R6 irq masked");

    // R2/R4: square wave, divider 1
    mode = 2;
    wr(3'd4, 32'h1 << 18);
    wr(3'd1, 32'd1);
    wr(3'd3, 32'h000C_0000);
    repeat (150) @(negedge clk);
    rd(3'd2, "R2", v);
    mode = 0;
    repeat (150) @(negedge clk);
    rd(3'd2, "R4", v);
    rd(3'd7, "R10", v);
    expect_eq(v, 32'h0, "R10 unmapped address");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule